// File: doc/BRIEF.md
# Transfer Data Mover for a Two-Wire Bus Master

This block sits between a two-wire bus master sequencer and the places that bytes come from or go to. When the sequencer needs a byte to send, it pulls one. When it has received a byte, it pushes it. The mover serves each request from one of three sources, chosen per direction by a small set of mode flags:

- a single byte register;
- a window into a local buffer-pool RAM, which a host can also reach through its own little-endian port;
- a stream to system memory, one byte per request on a simple request/acknowledge memory port.

The mover keeps the pool control word, which holds the counts, the window offset and the received count. It also keeps the memory stream address and remaining length. It clears the mode flag of an operation once that operation completes.

Top module: `pool_dma_mover`

## Requirements
- R1: The byte register keeps the transmit byte in bits 7:0. A software write loads bits 7:0 and clears bits 15:8. In byte mode, a pull answers on the following cycle with bits 7:0 and `tx_last`=1. In byte mode, a push replaces the register with the received byte in bits 15:8 and zeros in bits 7:0, and answers with `rx_ack` and `rx_more`=0.
- R2: The mode flags are: bit 0 pool transmit, bit 1 memory transmit, bit 2 pool receive, bit 3 memory receive. Within each direction, pool wins over memory, and memory wins over byte mode. Writing the flags resets both pool indices to zero.
- R3: In the pool control word, transmit count = bits 15:8 + 1, receive size = bits 23:16 + 1, and bits 5:0 are the window offset. A software write changes bits 23:0 only. Bits 31:24 are written by the mover with the number of bytes received.
- R4: The window base is chosen by a parameter: bus number × 16, bus number × 32, or page × 256 + offset × 4. Every pool address wraps modulo the pool size.
- R5: A write to the stream address clears bits 1:0. A write to the stream length keeps only its low 12 bits.
- R6: Pool transmit works as follows. An address pull returns window byte 0 and moves the index to 1. A data pull returns the byte at the index and then advances the index. `tx_last` marks the byte that reaches the transmit count. A data pull at or beyond the count answers `tx_none`.
- R7: Pool receive stores each pushed byte at window index = received count, then writes count + 1 into bits 31:24. It answers with `rx_more`=1 while that new count is below the receive size.
- R8: The mover clears a mode flag on completion: transmit flags after the last byte or a `tx_none`, receive flags when the size or the length is reached. `tx_nak` clears both transmit flags.
- R9: A memory stream byte is one request, held with a stable address until it is acknowledged. Each good transfer adds one to the address and subtracts one from the length, and an address pull also consumes length. A pull with length zero answers `tx_none`.
- R10: A memory error during receive answers `rx_ack` with `rx_fail`=1 and `rx_more`=0. It clears the memory receive flag and leaves the address and length unchanged.
- R11: The host pool port accepts byte (size 0), halfword (size 1) and word (size 2) accesses. Byte i of the data maps to address+i. Read data appears one cycle after the request, with unused lanes at zero.
- R12: After reset, every register and mode flag is zero and no response is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | 0 byte, 1 pool control, 2 stream address, 3 stream length, 4 mode flags |
| reg_wdata | input | 32 | Register write data |
| byte_reg | output | 16 | Byte register |
| pool_ctrl | output | 32 | Pool control word |
| dma_addr | output | ADDR_W | Stream address |
| dma_len | output | LEN_W | Stream remaining length |
| mode_flags | output | 4 | Mode flags |
| page_sel | input | 3 | Page for the paged window base |
| pool_en | input | 1 | Host pool access strobe |
| pool_we | input | 1 | Host pool write |
| pool_size | input | 2 | Access size |
| pool_addr | input | PAW | Host pool byte address |
| pool_wdata | input | 32 | Host write data |
| pool_rdata | output | 32 | Host read data |
| tx_pull | input | 1 | Sequencer requests a transmit byte |
| tx_addr | input | 1 | The pull is for the address byte |
| tx_nak | input | 1 | Target refused a byte |
| tx_vld | output | 1 | Transmit byte valid pulse |
| tx_none | output | 1 | No byte available pulse |
| tx_last | output | 1 | Byte is the last of the operation |
| tx_data | output | 8 | Transmit byte |
| rx_push | input | 1 | Sequencer delivers a received byte |
| rx_data | input | 8 | Received byte |
| rx_ack | output | 1 | Received byte handled pulse |
| rx_more | output | 1 | More bytes wanted |
| rx_fail | output | 1 | Memory error on this byte |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 8 | Memory read byte |
| mem_err | input | 1 | Memory error with acknowledge |

## Verification
A wrong pool index or window base shows up within one response as an unexpected byte on `tx_data`, or as a misplaced byte in a later host read. A stale count appears in bits 31:24 and in the `rx_more` of the same response. A flag left set, or a length that is stepped wrongly, shows on `mode_flags` and `dma_len` as soon as the operation ends, and it sends the next pull to the wrong source. Errors in the stream address show on `mem_addr` during the request and in where the bench memory model places bytes.

// File: rtl/pool_dma_mover.sv
module pool_dma_mover #(
  parameter int POOL_BYTES = 256,
  parameter int BASE_MODE  = 1,
  parameter int BUS_ID     = 2,
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 12,
  localparam int PAW       = $clog2(POOL_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_sel,
  input  logic [31:0]       reg_wdata,
  output logic [15:0]       byte_reg,
  output logic [31:0]       pool_ctrl,
  output logic [ADDR_W-1:0] dma_addr,
  output logic [LEN_W-1:0]  dma_len,
  output logic [3:0]        mode_flags,
  input  logic [2:0]        page_sel,
  input  logic              pool_en,
  input  logic              pool_we,
  input  logic [1:0]        pool_size,
  input  logic [PAW-1:0]    pool_addr,
  input  logic [31:0]       pool_wdata,
  output logic [31:0]       pool_rdata,
  input  logic              tx_pull,
  input  logic              tx_addr,
  input  logic              tx_nak,
  output logic              tx_vld,
  output logic              tx_none,
  output logic              tx_last,
  output logic [7:0]        tx_data,
  input  logic              rx_push,
  input  logic [7:0]        rx_data,
  output logic              rx_ack,
  output logic              rx_more,
  output logic              rx_fail,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic              mem_ack,
  input  logic [7:0]        mem_rdata,
  input  logic              mem_err
);
  logic [7:0] pool [POOL_BYTES];
  logic [7:0] tx_idx, rx_cnt;
  logic       busy, op_rx;
  logic [PAW-1:0] base;

  wire [8:0] tx_total = 9'(pool_ctrl[15:8]) + 9'd1;
  wire [8:0] rx_total = 9'(pool_ctrl[23:16]) + 9'd1;
  wire tx_pool = mode_flags[0];
  wire tx_dma  = !mode_flags[0] && mode_flags[1];
  wire rx_pool = mode_flags[2];
  wire rx_dma  = !mode_flags[2] && mode_flags[3];

  generate
    if (BASE_MODE == 0) begin : g_b16
      assign base = PAW'(BUS_ID * 16);
    end else if (BASE_MODE == 1) begin : g_b32
      assign base = PAW'(BUS_ID * 32);
    end else begin : g_page
      assign base = PAW'(32'(page_sel) * 256 + 32'(pool_ctrl[5:0]) * 4);
    end
  endgenerate

  wire [7:0]     tx_sel  = tx_addr ? 8'd0 : tx_idx;
  wire [PAW-1:0] tx_ptr  = base + PAW'(tx_sel);
  wire [PAW-1:0] rx_ptr  = base + PAW'(rx_cnt);
  wire [8:0]     tx_next = 9'(tx_sel) + 9'd1;
  wire [8:0]     rx_next = 9'(rx_cnt) + 9'd1;
  wire idle_rx = !busy && !tx_pull && !tx_nak && rx_push;
  wire pool_mw = idle_rx && rx_pool;
  wire [2:0] nbytes = (pool_size == 2'd0) ? 3'd1 : (pool_size == 2'd1) ? 3'd2 : 3'd4;

  always_ff @(posedge clk) begin
    for (int i = 0; i < 4; i++) begin
      if (pool_en && pool_we && 3'(i) < nbytes)
        pool[pool_addr + PAW'(i)] <= pool_wdata[8*i +: 8];
      if (pool_en && !pool_we)
        pool_rdata[8*i +: 8] <= (3'(i) < nbytes) ? pool[pool_addr + PAW'(i)] : 8'h00;
    end
    if (pool_mw) pool[rx_ptr] <= rx_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_reg <= '0; pool_ctrl <= '0; dma_addr <= '0; dma_len <= '0; mode_flags <= '0;
      tx_idx <= '0; rx_cnt <= '0; busy <= 1'b0; op_rx <= 1'b0;
      tx_vld <= 1'b0; tx_none <= 1'b0; tx_last <= 1'b0; tx_data <= '0;
      rx_ack <= 1'b0; rx_more <= 1'b0; rx_fail <= 1'b0;
      mem_req <= 1'b0; mem_we <= 1'b0; mem_addr <= '0; mem_wdata <= '0;
    end else begin
      tx_vld <= 1'b0; tx_none <= 1'b0; rx_ack <= 1'b0; rx_fail <= 1'b0;
      if (reg_we) begin
        case (reg_sel)
          3'd0: byte_reg <= {8'h00, reg_wdata[7:0]};
          3'd1: pool_ctrl[23:0] <= reg_wdata[23:0];
          3'd2: dma_addr <= {reg_wdata[ADDR_W-1:2], 2'b00};
          3'd3: dma_len <= reg_wdata[LEN_W-1:0];
          3'd4: begin mode_flags <= reg_wdata[3:0]; tx_idx <= '0; rx_cnt <= '0; end
          default: ;
        endcase
      end
      if (!busy) begin
        if (tx_pull) begin
          if (tx_pool) begin
            if (!tx_addr && {1'b0, tx_idx} >= tx_total) begin
              tx_none <= 1'b1; mode_flags[0] <= 1'b0;
            end else begin
              tx_vld <= 1'b1; tx_data <= pool[tx_ptr];
              tx_last <= tx_next >= tx_total;
              tx_idx <= tx_next[7:0];
              if (tx_next >= tx_total) mode_flags[0] <= 1'b0;
            end
          end else if (tx_dma) begin
            if (dma_len == '0) begin
              tx_none <= 1'b1; mode_flags[1] <= 1'b0;
            end else begin
              busy <= 1'b1; op_rx <= 1'b0; mem_req <= 1'b1; mem_we <= 1'b0; mem_addr <= dma_addr;
            end
          end else begin
            tx_vld <= 1'b1; tx_data <= byte_reg[7:0]; tx_last <= 1'b1;
          end
        end else if (tx_nak) begin
          mode_flags[1:0] <= 2'b00;
        end else if (rx_push) begin
          if (rx_pool) begin
            rx_cnt <= rx_next[7:0]; pool_ctrl[31:24] <= rx_next[7:0];
            rx_ack <= 1'b1; rx_more <= rx_next < rx_total;
            if (rx_next >= rx_total) mode_flags[2] <= 1'b0;
          end else if (rx_dma) begin
            if (dma_len == '0) begin
              rx_ack <= 1'b1; rx_more <= 1'b0; mode_flags[3] <= 1'b0;
            end else begin
              busy <= 1'b1; op_rx <= 1'b1; mem_req <= 1'b1; mem_we <= 1'b1;
              mem_addr <= dma_addr; mem_wdata <= rx_data;
            end
          end else begin
            byte_reg <= {rx_data, 8'h00}; rx_ack <= 1'b1; rx_more <= 1'b0;
          end
        end
      end else if (mem_ack) begin
        busy <= 1'b0; mem_req <= 1'b0;
        if (mem_err) begin
          if (op_rx) begin
            rx_ack <= 1'b1; rx_fail <= 1'b1; rx_more <= 1'b0; mode_flags[3] <= 1'b0;
          end else begin
            tx_none <= 1'b1; mode_flags[1] <= 1'b0;
          end
        end else begin
          dma_addr <= dma_addr + 1'b1;
          dma_len <= dma_len - 1'b1;
          if (op_rx) begin
            rx_ack <= 1'b1; rx_more <= dma_len != LEN_W'(1);
            if (dma_len == LEN_W'(1)) mode_flags[3] <= 1'b0;
          end else begin
            tx_vld <= 1'b1; tx_data <= mem_rdata; tx_last <= dma_len == LEN_W'(1);
            if (dma_len == LEN_W'(1)) mode_flags[1] <= 1'b0;
          end
        end
      end
    end
  end

  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && reg_sel == 3'd2 && !busy |=> dma_addr[1:0] == 2'b00); // R5
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr)); // R9
  AST_ONE_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_vld, tx_none, rx_ack})); // R2
  AST_ERR_KEEPS_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy && mem_ack && mem_err && !reg_we |=> $stable(dma_len) && $stable(dma_addr) && rx_ack == op_rx); // R10
  AST_RXCNT_HW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && reg_sel == 3'd1 && !pool_mw |=> $stable(pool_ctrl[31:24])); // R3
  AST_NAK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_nak && !tx_pull && !busy && !reg_we |=> mode_flags[1:0] == 2'b00); // R8
endmodule

// File: tb/pool_dma_mover_test.sv
module pool_dma_mover_test;
  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic reg_we = 0; logic [2:0] reg_sel = 0; logic [31:0] reg_wdata = 0;
  logic [15:0] byte_reg; logic [31:0] pool_ctrl, dma_addr; logic [11:0] dma_len; logic [3:0] mode_flags;
  logic [2:0] page_sel = 0;
  logic pool_en = 0, pool_we = 0; logic [1:0] pool_size = 0; logic [7:0] pool_addr = 0;
  logic [31:0] pool_wdata = 0, pool_rdata;
  logic tx_pull = 0, tx_addr = 0, tx_nak = 0, tx_vld, tx_none, tx_last; logic [7:0] tx_data;
  logic rx_push = 0; logic [7:0] rx_data = 0; logic rx_ack, rx_more, rx_fail;
  logic mem_req, mem_we; logic [31:0] mem_addr; logic [7:0] mem_wdata;
  logic mem_ack = 0, mem_err = 0; logic [7:0] mem_rdata = 0;
  logic [7:0] smem [256];
  logic mdly = 0;

  int vectors = 0, miscompares = 0;
  logic [10:0] exp_q[$];
  string tag_q[$];

  pool_dma_mover uut (.*);

  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (mem_req && !mem_ack) begin
      if (mdly) begin
        mdly <= 1'b0; mem_ack <= 1'b1;
        mem_rdata <= mem_addr[7:0] ^ 8'h5A;
        mem_err <= (mem_addr == 32'h40);
        if (mem_we && mem_addr != 32'h40) smem[mem_addr[7:0]] <= mem_wdata;
      end else mdly <= 1'b1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && (tx_vld || tx_none || rx_ack)) begin
      logic [10:0] got;
      got = tx_vld ? {2'd0, tx_data, tx_last} : tx_none ? {2'd1, 8'd0, 1'b0} : {2'd2, 7'd0, rx_fail, rx_more};
      vectors++;
      if (exp_q.size() == 0) begin
        miscompares++; $display("FAIL unexpected response: actual %h expected none", got);
      end else begin
        logic [10:0] e; string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        if (got !== e) begin
          miscompares++; $display("FAIL %s: actual %h expected %h", t, got, e);
        end
      end
    end
  end

  task automatic chk(string t, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++; $display("FAIL %s: actual %h expected %h", t, act, exp);
    end
  endtask

  task automatic drain();
    int n = 0;
    while (exp_q.size() != 0 && n < 50) begin @(posedge clk); n++; end
    if (exp_q.size() != 0) begin
      miscompares++; $display("FAIL %s: actual no response expected %h", tag_q[0], exp_q[0]);
      exp_q.delete(); tag_q.delete();
    end
    @(negedge clk);
  endtask

  task automatic wr(logic [2:0] s, logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_sel = s; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic pull(bit a, logic [7:0] d, bit last, bit none, string t);
    exp_q.push_back(none ? {2'd1, 8'd0, 1'b0} : {2'd0, d, last}); tag_q.push_back(t);
    @(negedge clk); tx_pull = 1; tx_addr = a;
    @(negedge clk); tx_pull = 0; tx_addr = 0;
    drain();
  endtask

  task automatic push(logic [7:0] d, bit fail, bit more, string t);
    exp_q.push_back({2'd2, 7'd0, fail, more}); tag_q.push_back(t);
    @(negedge clk); rx_push = 1; rx_data = d;
    @(negedge clk); rx_push = 0;
    drain();
  endtask

  task automatic pwr(logic [7:0] a, logic [1:0] sz, logic [31:0] d);
    @(negedge clk); pool_en = 1; pool_we = 1; pool_addr = a; pool_size = sz; pool_wdata = d;
    @(negedge clk); pool_en = 0; pool_we = 0;
  endtask

  task automatic prd(logic [7:0] a, logic [1:0] sz, output logic [31:0] d);
    @(negedge clk); pool_en = 1; pool_addr = a; pool_size = sz;
    @(negedge clk); pool_en = 0; d = pool_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++; $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    chk("R12 byte_reg", 32'(byte_reg), 0); chk("R12 pool_ctrl", pool_ctrl, 0);
    chk("R12 mode", 32'(mode_flags), 0); chk("R12 len", 32'(dma_len), 0);
    rst_n = 1; @(negedge clk);

    wr(0, 32'h1234A5);
    chk("R1 byte write", 32'(byte_reg), 32'h00A5);
    pull(0, 8'hA5, 1, 0, "R1 byte tx");
    push(8'h3C, 0, 0, "R1 byte rx");
    chk("R1 byte rx store", 32'(byte_reg), 32'h3C00);

    wr(1, 32'hFF000200);
    chk("R3 sw write bits 23:0 only", pool_ctrl, 32'h00000200);

    pwr(8'd64, 2'd2, 32'h44332211);
    pwr(8'd65, 2'd0, 32'hAABBCC77);
    prd(8'd64, 2'd2, rd); chk("R11 word read after byte write", rd, 32'h44337711);
    prd(8'd66, 2'd1, rd); chk("R11 half read", rd, 32'h00004433);

    wr(4, 32'h1);
    pull(1, 8'h11, 0, 0, "R6 R4 pool address byte");
    pull(0, 8'h77, 0, 0, "R6 pool data 1");
    pull(0, 8'h33, 1, 0, "R6 pool last");
    chk("R8 pool tx flag cleared", 32'(mode_flags), 0);
    pull(0, 8'h00, 1, 0, "R2 falls back to byte mode");

    wr(1, 32'h00010000);
    wr(4, 32'h4);
    push(8'h9A, 0, 1, "R7 pool rx 1");
    push(8'h9B, 0, 0, "R7 pool rx 2");
    chk("R3 R7 rx count in 31:24", pool_ctrl, 32'h02010000);
    chk("R8 pool rx flag cleared", 32'(mode_flags), 0);
    prd(8'd64, 2'd2, rd); chk("R7 pool rx bytes", rd, 32'h44339B9A);
    wr(1, 32'hAB000200);
    chk("R3 hw count kept", pool_ctrl, 32'h02000200);

    wr(2, 32'h1003); chk("R5 address aligned", dma_addr, 32'h1000);
    wr(3, 32'hF003); chk("R5 length 12 bits", 32'(dma_len), 32'h003);
    wr(4, 32'h2);
    pull(1, 8'h5A, 0, 0, "R9 stream address byte");
    chk("R9 address pull consumes length", 32'(dma_len), 2);
    pull(0, 8'h5B, 0, 0, "R9 stream data");
    pull(0, 8'h58, 1, 0, "R9 stream last");
    chk("R9 address advanced", dma_addr, 32'h1003);
    chk("R8 stream tx flag cleared", 32'(mode_flags), 0);
    wr(4, 32'h2);
    pull(0, 8'h00, 0, 1, "R9 zero length none");
    chk("R8 flag cleared after none", 32'(mode_flags), 0);

    wr(3, 32'h5);
    wr(4, 32'h3);
    pull(0, 8'h9A, 0, 0, "R2 pool over stream");
    chk("R2 stream length untouched", 32'(dma_len), 5);
    @(negedge clk); tx_nak = 1; @(negedge clk); tx_nak = 0;
    chk("R8 nak clears tx flags", 32'(mode_flags), 0);

    wr(1, 32'h00010000);
    wr(4, 32'hC);
    push(8'h11, 0, 1, "R2 rx pool over stream");
    chk("R2 rx stream length untouched", 32'(dma_len), 5);

    wr(2, 32'h20); wr(3, 32'h2); wr(4, 32'h8);
    push(8'h71, 0, 1, "R9 stream rx 1");
    push(8'h72, 0, 0, "R9 stream rx 2");
    chk("R9 memory byte 0", 32'(smem[8'h20]), 32'h71);
    chk("R9 memory byte 1", 32'(smem[8'h21]), 32'h72);
    chk("R9 rx address", dma_addr, 32'h22);
    chk("R8 rx stream flag cleared", 32'(mode_flags) | 32'(dma_len), 0);

    wr(2, 32'h40); wr(3, 32'h3); wr(4, 32'h8);
    push(8'h55, 1, 0, "R10 memory error");
    chk("R10 address kept", dma_addr, 32'h40);
    chk("R10 length kept", 32'(dma_len), 3);
    chk("R10 flag cleared", 32'(mode_flags), 0);

    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule